// File: doc/BRIEF.md
# MDIO Station Management Master

This block runs one PHY register access at a time over a two-wire management link: a management clock (MDC) and a bidirectional data line (MDIO). The host pulses `start_i` with a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then sends the complete serial frame and raises `done_o` for one cycle when the frame is finished. For a read, the word it collects from the PHY appears on `rdata_o`.

MDIO is brought out as three signals: an output, an output enable and an input. An external pad can then tristate the line. MDC comes from an internal half-period timer. It runs only while a frame is in flight and is otherwise held low.

Every frame has the same header:
- a 32-bit run of ones;
- the start code 01;
- a 2-bit opcode;
- the PHY address;
- the register address.

A write then drives the turnaround 10 and the data word. A read releases the line, gives one pulse with nothing sampled, and then collects 16 bits.

Top module: `mdio_master`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `mdc_o` and `mdio_oe_o` are all low.
- R2: Each frame starts with 32 MDC pulses during which MDIO is driven to 1. The next two pulses carry 0 and then 1.
- R3: Pulses 34 and 35, counted from 0, carry the opcode. A write (`wr_i`=1) sends 0,1 and a read (`wr_i`=0) sends 1,0.
- R4: Pulses 36 to 40 carry `phy_addr_i` from bit 4 down to bit 0. Pulses 41 to 45 carry `reg_addr_i` in the same bit order.
- R5: A write frame is exactly 64 pulses with the output enable high on every one. Pulses 46 and 47 carry 1,0 and pulses 48 to 63 carry `wdata_i` from bit 15 down to bit 0.
- R6: A read frame is exactly 63 pulses. The output enable is high on pulses 0 to 45 and low on pulses 46 to 62. Pulse 46 is never sampled. MDIO is sampled as MDC falls at the end of each of pulses 47 to 62, and the first bit taken becomes `rdata_o[15]`.
- R7: Each bit occupies one MDC period: HALF_CYC system clocks low, then HALF_CYC clocks high. MDIO changes only while MDC is low, so each bit is set up before MDC rises.
- R8: At the end of a frame `busy_o` falls, `mdio_oe_o` goes low and MDC is low. `done_o` is high for exactly one cycle per frame.
- R9: A start pulse while `busy_o` is high is ignored. The current frame's length and content are unchanged and no second frame follows.
- R10: `rdata_o` keeps its value between frames, whatever MDIO does while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a frame; taken only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data collected by the last read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that reset is applied from time zero and that HALF_CYC is at least 1. They also assume that a rise of `busy_o` can only follow a start pulse seen while the block was idle. Command fields are sampled only in the accept cycle, so nothing is assumed about them at other times.

The stimulus drives every input half a clock away from the active edge and makes each start pulse one cycle wide. The modelled PHY changes `mdio_i` only just after MDC rises, which leaves a full half-period before the master samples.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned PRE_BITS  = 32;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned HDR_BITS  = PRE_BITS + 2 + 2 + 2 * ADDR_W;
  localparam int unsigned WR_SLOTS  = HDR_BITS + 2 + DATA_W;
  localparam int unsigned RD_SLOTS  = HDR_BITS + 1 + DATA_W;
  localparam int unsigned FRAME_W   = WR_SLOTS;
  localparam int unsigned SLOT_W    = $clog2(WR_SLOTS);

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [FRAME_W-1:0] frame_t;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_CODE  = 2'b10;

  function automatic frame_t build_frame(logic is_wr, addr_t pa, addr_t ra, word_t wd);
    return {{PRE_BITS{1'b1}}, SOF_CODE, (is_wr ? OP_WR : OP_RD), pa, ra, TA_CODE, wd};
  endfunction
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int unsigned HALF_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clear_i || !run_i)           cnt_q <= '0;
    else if (cnt_q == CNT_MAX)            cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && !clear_i && (cnt_q == CNT_MAX);

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  a_r7_idle_cnt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> cnt_q == '0);
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= frame_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign bit_o = sr_q[W-1];

  a_r7_hold_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) && !$past(shift_i) |-> $stable(bit_o));
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_o <= '0;
    else if (sample_i)  data_o <= {data_o[W-2:0], bit_i};
  end

  a_r10_keep_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_i) |-> $stable(data_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CYC = 25
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam logic [SLOT_W-1:0] LAST_WR   = SLOT_W'(WR_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LAST_RD   = SLOT_W'(RD_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LAST_HDR  = SLOT_W'(HDR_BITS - 1);
  localparam logic [SLOT_W-1:0] FIRST_RX  = SLOT_W'(HDR_BITS + 1);

  logic              busy_q, is_wr_q, mdc_q, oe_q, done_q;
  logic [SLOT_W-1:0] slot_q;
  logic              accept, tick, rise, fall, at_last, shift, sample;
  logic [SLOT_W-1:0] last_slot;

  assign accept    = start_i && !busy_q;
  assign rise      = tick && !mdc_q;
  assign fall      = tick && mdc_q;
  assign last_slot = is_wr_q ? LAST_WR : LAST_RD;
  assign at_last   = (slot_q == last_slot);
  assign shift     = fall && !at_last;
  // samples are taken as MDC falls, after the PHY has had the whole pulse
  assign sample    = fall && !is_wr_q && (slot_q >= FIRST_RX);

  mdio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_q),
    .clear_i (accept),
    .tick_o  (tick)
  );

  mdio_tx_shift #(.W(FRAME_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .frame_i (build_frame(wr_i, phy_addr_i, reg_addr_i, wdata_i)),
    .shift_i (shift),
    .bit_o   (mdio_o)
  );

  mdio_rx_shift #(.W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .bit_i    (mdio_i),
    .data_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      is_wr_q <= 1'b0;
      mdc_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      slot_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        is_wr_q <= wr_i;
        mdc_q   <= 1'b0;
        oe_q    <= 1'b1;
        slot_q  <= '0;
      end else if (busy_q) begin
        if (rise) begin
          mdc_q <= 1'b1;
        end else if (fall) begin
          mdc_q <= 1'b0;
          if (at_last) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
            // release the line once the register address has gone out
            if (!is_wr_q && slot_q == LAST_HDR) oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign mdc_o     = mdc_q;
  assign mdio_oe_o = oe_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o && !mdc_o);
  a_r7_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o && $past(mdc_o) |-> $stable(mdio_o));
  a_r8_done_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  a_r9_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r6_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) && busy_o |-> !is_wr_q && !mdc_o);
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF)) u_mdio_master (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .wr_i(wr_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY model and pulse capture
  logic        cap_d [0:255];
  logic        cap_oe[0:255];
  int          npulse = 0;
  int          frame_base = 0;
  logic [15:0] phy_word = '0;
  logic        phy_bit = 1'b1;
  logic        noise = 1'b0;
  assign mdio_i = phy_bit ^ noise;

  always @(posedge mdc_o) begin
    int k;
    k = npulse - frame_base;
    cap_d[npulse % 256]  = mdio_o;
    cap_oe[npulse % 256] = mdio_oe_o;
    if (k >= 47 && k <= 62) phy_bit = phy_word[62-k];
    else if (k == 46)       phy_bit = 1'b0;
    else                    phy_bit = 1'b1;
    npulse++;
  end

  // timing monitor
  logic prev_mdc = 1'b0, prev_mdio = 1'b0;
  int hi_run = 0, lo_run = 0, viol = 0, bad_w = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (mdc_o && prev_mdc && mdio_o !== prev_mdio) viol++;
    if (mdc_o != prev_mdc) begin
      if (prev_mdc) begin if (hi_run != HALF) bad_w++; end
      else if (lo_run != HALF) bad_w++;
      hi_run = 0; lo_run = 0;
    end
    if (mdc_o) hi_run++; else lo_run++;
    if (!busy_o) lo_run = 0;
    if (done_o) done_cnt++;
    prev_mdc  = mdc_o;
    prev_mdio = mdio_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(logic w, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), pa, ra, 2'b10, wd};
  endfunction

  function automatic int mism(logic [63:0] f, int lo, int hi);
    int m = 0;
    for (int i = lo; i <= hi; i++)
      if (cap_d[(frame_base + i) % 256] !== f[63-i]) m++;
    return m;
  endfunction

  function automatic int oe_mism(logic v, int lo, int hi);
    int m = 0;
    for (int i = lo; i <= hi; i++)
      if (cap_oe[(frame_base + i) % 256] !== v) m++;
    return m;
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic launch(input logic w, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    @(negedge clk);
    frame_base = npulse;
    done_cnt   = 0;
    wr_i = w; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic end_checks(input int exp_pulses, input string tag);
    repeat (3) @(negedge clk);
    check(npulse - frame_base == exp_pulses, tag, npulse - frame_base, exp_pulses);
    check(!busy_o && !mdio_oe_o && !mdc_o, "R8 idle after frame",
          {busy_o, mdio_oe_o, mdc_o}, 0);
    check(done_cnt == 1, "R8 done pulses", done_cnt, 1);
    check(viol == 0, "R7 mdio change while mdc high", viol, 0);
    check(bad_w == 0, "R7 half-period width", bad_w, 0);
  endtask

  task automatic t_reset();
    check(!busy_o && !done_o && !mdc_o && !mdio_oe_o, "R1 in reset",
          {busy_o, done_o, mdc_o, mdio_oe_o}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mdc_o && !mdio_oe_o, "R1 after reset",
          {busy_o, done_o, mdc_o, mdio_oe_o}, 0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    logic [63:0] f;
    bit ok;
    f = exp_frame(1'b1, pa, ra, wd);
    launch(1'b1, pa, ra, wd);
    check(busy_o, "R8 busy during write", busy_o, 1);
    wait_done(ok);
    check(ok, "R8 write done seen", ok, 1);
    end_checks(64, "R5 write pulse count");
    check(mism(f, 0, 33) == 0, "R2 preamble and start", mism(f, 0, 33), 0);
    check(mism(f, 34, 35) == 0, "R3 write opcode", mism(f, 34, 35), 0);
    check(mism(f, 36, 45) == 0, "R4 addresses", mism(f, 36, 45), 0);
    check(mism(f, 46, 63) == 0, "R5 turnaround and data", mism(f, 46, 63), 0);
    check(oe_mism(1'b1, 0, 63) == 0, "R5 oe held", oe_mism(1'b1, 0, 63), 0);
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] word);
    logic [63:0] f;
    bit ok;
    f = exp_frame(1'b0, pa, ra, 16'h0);
    phy_word = word;
    launch(1'b0, pa, ra, 16'hFFFF);
    wait_done(ok);
    check(ok, "R8 read done seen", ok, 1);
    end_checks(63, "R6 read pulse count");
    check(mism(f, 0, 33) == 0, "R2 preamble and start", mism(f, 0, 33), 0);
    check(mism(f, 34, 35) == 0, "R3 read opcode", mism(f, 34, 35), 0);
    check(mism(f, 36, 45) == 0, "R4 addresses", mism(f, 36, 45), 0);
    check(oe_mism(1'b1, 0, 45) == 0, "R6 oe in header", oe_mism(1'b1, 0, 45), 0);
    check(oe_mism(1'b0, 46, 62) == 0, "R6 released", oe_mism(1'b0, 46, 62), 0);
    check(rdata_o == word, "R6 read data", rdata_o, word);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] f;
    bit ok;
    f = exp_frame(1'b1, 5'h0A, 5'h15, 16'h5A3C);
    launch(1'b1, 5'h0A, 5'h15, 16'h5A3C);
    repeat (20) @(negedge clk);
    wr_i = 1'b0; phy_addr_i = 5'h1F; reg_addr_i = 5'h00; wdata_i = 16'h0000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(ok);
    repeat (300) @(negedge clk);
    check(npulse - frame_base == 64, "R9 no extra frame", npulse - frame_base, 64);
    check(mism(f, 0, 63) == 0, "R9 frame unchanged", mism(f, 0, 63), 0);
    check(done_cnt == 1, "R9 one done", done_cnt, 1);
  endtask

  task automatic t_rdata_hold();
    logic [15:0] keep;
    t_read(5'h03, 5'h1C, 16'hC0DE);
    keep = rdata_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      noise = ~noise;
    end
    noise = 1'b0;
    check(rdata_o == keep, "R10 rdata idle hold", rdata_o, keep);
    t_write(5'h11, 5'h0E, 16'h1234);
    check(rdata_o == keep, "R10 rdata across write", rdata_o, keep);
  endtask

  initial begin
    t_reset();
    t_write(5'h01, 5'h02, 16'hA5C3);
    t_write(5'h1F, 5'h1F, 16'hFFFF);
    t_write(5'h00, 5'h00, 16'h0001);
    t_read(5'h05, 5'h10, 16'h8001);
    t_read(5'h1F, 5'h01, 16'h7FFE);
    t_read(5'h00, 5'h00, 16'h0000);
    t_busy_ignore();
    t_rdata_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule